// File: doc/BRIEF.md
# Transducer Frequency Sweep Controller

This block runs a frequency-response scan of an ultrasonic transmitter and receiver pair. A single `go` pulse starts the scan. The controller then steps a drive half period, counted in system clock ticks, upward from a programmed first value to a programmed last value. The drive tone therefore has the frequency f_clk / (2 × half period); with a 16 MHz clock a half period of 195 gives roughly 41 kHz. The block keeps the external tone generator running throughout the scan and reads back one pulse per completed drive cycle.

Each half-period step starts with a settling phase. During that phase the controller only counts drive cycles, so that the transducer response reaches a steady state. Once settled, it emits one framed record on a valid/ready stream: an all-ones marker word, then the half period, then a fixed number of converter samples. The controller fetches samples one at a time with a request/response exchange. It asks for a new sample only after the previous one has left on the stream, so back-pressure never loses data.

States: `ST_IDLE` (waiting for go), `ST_SETTLE` (counting drive cycles), `ST_MARK` (marker word offered), `ST_PERIOD` (half-period word offered), `ST_REQ` (conversion requested), `ST_WAIT` (awaiting the converter), `ST_SEND` (sample offered). Transitions: `ST_IDLE`→`ST_SETTLE` on go. `ST_SETTLE`→`ST_MARK` on the drive pulse that completes the settle count. `ST_MARK`→`ST_PERIOD` and `ST_PERIOD`→`ST_REQ` on acceptance. `ST_REQ`→`ST_WAIT` always. `ST_WAIT`→`ST_SEND` on converter valid. `ST_SEND`→`ST_REQ` on acceptance of a non-final sample. `ST_SEND`→`ST_SETTLE` on acceptance of the final sample when the last step is not yet reached, with the half period incremented. `ST_SEND`→`ST_IDLE` on acceptance of the final sample of the last step.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: After reset `busy`, `drv_en`, `adc_req`, `rec_valid` and `rec_last` are low. While `busy` is low, `rec_valid` and `adc_req` stay low.
- R2: A go pulse while idle latches the first value, last value and settle count. The block then emits exactly one record per half period from the first value to the last value, inclusive and ascending. If the first value exceeds the last value, only one record is emitted, for the first value.
- R3: A record is the word 16'hFFFF (all ones), then the half period zero-extended, then NUM_SAMPLES samples zero-extended in the order they were converted. `rec_last` is high only with the final sample of a record.
- R4: `drv_en` is high exactly while `busy` is high. `drv_half_period` shows the half period of the record being settled or emitted, and changes during a scan only after the final word of a record is accepted.
- R5: The marker of a record is offered only on the cycle after the drive pulse that completes the settle count. Pulses are counted from the go edge, or from the acceptance of the previous record's final word. A settle setting of 0 selects 64 drive cycles.
- R6: `adc_req` is a one-cycle pulse. No new request is issued until the previous sample has been accepted on the stream, so under any pattern of `rec_ready` every converted sample is delivered once, with none dropped.
- R7: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_data` and `rec_last` hold their values.
- R8: `busy` rises on the go edge and falls on the edge that accepts the final word of the last record. A go pulse, or a change on the configuration inputs, while busy has no effect on the scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; half periods are counted in its ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_hp | input | HP_W | First half period of the scan |
| cfg_end_hp | input | HP_W | Last half period of the scan |
| cfg_settle | input | SETTLE_W | Drive cycles to wait before each capture (0 selects 64) |
| go | input | 1 | Start pulse, honoured only while idle |
| busy | output | 1 | High for the whole scan |
| drv_en | output | 1 | Enables the external tone generator |
| drv_half_period | output | HP_W | Half period the generator should use |
| drv_cycle | input | 1 | One-cycle pulse per completed drive cycle |
| adc_req | output | 1 | One-cycle conversion request |
| adc_valid | input | 1 | Converter result strobe |
| adc_data | input | ADC_W | Converter result |
| rec_valid | output | 1 | Record word available |
| rec_ready | input | 1 | Sink accepts the current word |
| rec_data | output | REC_W | Record word: marker, half period or sample |
| rec_last | output | 1 | Marks the final sample of a record |

## Verification
The checker assumes that the converter answers each request exactly once, with a single-cycle `adc_valid`, and never strobes it spontaneously. It also assumes that `drv_cycle` is a single-cycle pulse that only occurs while `drv_en` is high. The marker check further relies on REC_W being wider than both ADC_W and HP_W, so that no sample or half-period word can equal all ones. The bench models a converter with fixed latency and a running sample count that answers only on request, and it flags any request issued while a conversion is still outstanding. Its tone generator pulses once every 2 × half period ticks while enabled. Sink stalls come from a pseudo-random pattern.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_MARK,
        ST_PERIOD,
        ST_REQ,
        ST_WAIT,
        ST_SEND
    } sweep_state_e;

endpackage

// File: rtl/sweep_hp_stepper.sv
module sweep_hp_stepper #(
    parameter int HP_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic [HP_W-1:0] first_i,
    input  logic [HP_W-1:0] last_i,
    output logic [HP_W-1:0] hp_o,
    output logic            at_end_o
);

    logic [HP_W-1:0] hp_q;
    logic [HP_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_q   <= '0;
            last_q <= '0;
        end else if (load) begin
            hp_q   <= first_i;
            last_q <= last_i;
        end else if (advance) begin
            hp_q   <= hp_q + 1'b1;
        end
    end

    // a first value above the last value ends the scan after one step
    assign at_end_o = (hp_q >= last_q);
    assign hp_o     = hp_q;

endmodule

// File: rtl/sweep_settle_timer.sv
module sweep_settle_timer #(
    parameter int SETTLE_W       = 16,
    parameter int SETTLE_DEFAULT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] cfg_i,
    input  logic                clr,
    input  logic                tick,
    output logic                done_o
);

    localparam logic [SETTLE_W-1:0] DEF_TARGET = SETTLE_W'(SETTLE_DEFAULT);

    logic [SETTLE_W-1:0] target_q;
    logic [SETTLE_W-1:0] cnt_q;
    logic [SETTLE_W:0]   cnt_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= DEF_TARGET;
        end else if (load) begin
            target_q <= (cfg_i == '0) ? DEF_TARGET : cfg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_next[SETTLE_W-1:0];
        end
    end

    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign done_o   = tick && (cnt_next >= {1'b0, target_q});

endmodule

// File: rtl/sweep_sample_counter.sv
module sweep_sample_counter #(
    parameter int NUM_SAMPLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_o
);

    localparam int CNT_W = (NUM_SAMPLES > 1) ? $clog2(NUM_SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SAMPLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST_IDX);

endmodule

// File: rtl/freq_sweep_ctrl.sv
module freq_sweep_ctrl
    import sweep_pkg::*;
#(
    parameter int HP_W           = 10,
    parameter int SETTLE_W       = 16,
    parameter int SETTLE_DEFAULT = 64,
    parameter int NUM_SAMPLES    = 1024,
    parameter int ADC_W          = 12,
    parameter int REC_W          = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HP_W-1:0]     cfg_start_hp,
    input  logic [HP_W-1:0]     cfg_end_hp,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic                go,
    output logic                busy,
    output logic                drv_en,
    output logic [HP_W-1:0]     drv_half_period,
    input  logic                drv_cycle,
    output logic                adc_req,
    input  logic                adc_valid,
    input  logic [ADC_W-1:0]    adc_data,
    output logic                rec_valid,
    input  logic                rec_ready,
    output logic [REC_W-1:0]    rec_data,
    output logic                rec_last
);

    localparam logic [REC_W-1:0] MARKER = '1;

    sweep_state_e st_q, st_d;

    logic [HP_W-1:0]  hp;
    logic             at_end;
    logic             settle_done;
    logic             smp_last;
    logic [ADC_W-1:0] smp_q;

    logic accept;
    logic load_cfg;
    logic step_next;
    logic restart_step;
    logic smp_take;

    assign accept       = rec_valid && rec_ready;
    assign load_cfg     = (st_q == ST_IDLE) && go;
    assign step_next    = (st_q == ST_SEND) && accept && smp_last && !at_end;
    assign restart_step = load_cfg || step_next;
    assign smp_take     = (st_q == ST_SEND) && accept;

    sweep_hp_stepper #(
        .HP_W (HP_W)
    ) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cfg),
        .advance  (step_next),
        .first_i  (cfg_start_hp),
        .last_i   (cfg_end_hp),
        .hp_o     (hp),
        .at_end_o (at_end)
    );

    sweep_settle_timer #(
        .SETTLE_W       (SETTLE_W),
        .SETTLE_DEFAULT (SETTLE_DEFAULT)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_cfg),
        .cfg_i  (cfg_settle),
        .clr    (restart_step),
        .tick   (drv_cycle && (st_q == ST_SETTLE)),
        .done_o (settle_done)
    );

    sweep_sample_counter #(
        .NUM_SAMPLES (NUM_SAMPLES)
    ) u_samples (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart_step),
        .inc    (smp_take),
        .last_o (smp_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // converted sample held until the stream takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else if ((st_q == ST_WAIT) && adc_valid) begin
            smp_q <= adc_data;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (go)          st_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) st_d = ST_MARK;
            ST_MARK:   if (accept)      st_d = ST_PERIOD;
            ST_PERIOD: if (accept)      st_d = ST_REQ;
            ST_REQ:                     st_d = ST_WAIT;
            ST_WAIT:   if (adc_valid)   st_d = ST_SEND;
            ST_SEND: begin
                if (accept) begin
                    if (!smp_last)   st_d = ST_REQ;
                    else if (at_end) st_d = ST_IDLE;
                    else             st_d = ST_SETTLE;
                end
            end
            default:                    st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy            = (st_q != ST_IDLE);
        drv_en          = busy;
        drv_half_period = hp;
        adc_req         = 1'b0;
        rec_valid       = 1'b0;
        rec_data        = '0;
        rec_last        = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_SETTLE, ST_WAIT: ;
            ST_MARK: begin
                rec_valid = 1'b1;
                rec_data  = MARKER;
            end
            ST_PERIOD: begin
                rec_valid = 1'b1;
                rec_data  = REC_W'(hp);
            end
            ST_REQ: adc_req = 1'b1;
            ST_SEND: begin
                rec_valid = 1'b1;
                rec_data  = REC_W'(smp_q);
                rec_last  = smp_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/freq_sweep_ctrl_chk.sv
module freq_sweep_ctrl_chk #(
    parameter int HP_W  = 10,
    parameter int REC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [HP_W-1:0]  drv_half_period,
    input logic             drv_cycle,
    input logic             adc_req,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [REC_W-1:0] rec_data,
    input logic             rec_last
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rec_valid && !adc_req));

    // R3
    last_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_last |-> rec_valid);

    // R4
    hp_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(drv_half_period) && $past(busy)) |->
            $past(rec_valid && rec_ready && rec_last));

    // R5
    settle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (&rec_data) && !$past(rec_valid)) |-> $past(drv_cycle));

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |=> !adc_req);

    // R6
    req_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |-> !rec_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=>
            (rec_valid && $stable(rec_data) && $stable(rec_last)));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rec_valid && rec_ready && rec_last));

endmodule

bind freq_sweep_ctrl freq_sweep_ctrl_chk #(
    .HP_W  (HP_W),
    .REC_W (REC_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy            (busy),
    .drv_half_period (drv_half_period),
    .drv_cycle       (drv_cycle),
    .adc_req         (adc_req),
    .rec_valid       (rec_valid),
    .rec_ready       (rec_ready),
    .rec_data        (rec_data),
    .rec_last        (rec_last)
);

// File: tb/freq_sweep_ctrl_bench.sv
`timescale 1ns/1ps
module freq_sweep_ctrl_bench;

    localparam int HP_W = 10, SW = 16, ADC_W = 12, REC_W = 16, NS = 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [HP_W-1:0]  cfg_start_hp = '0, cfg_end_hp = '0;
    logic [SW-1:0]    cfg_settle = '0;
    logic             go = 1'b0;
    logic             busy, drv_en, adc_req, rec_valid, rec_last;
    logic [HP_W-1:0]  drv_half_period;
    logic             drv_cycle = 1'b0;
    logic             adc_valid = 1'b0;
    logic [ADC_W-1:0] adc_data = '0;
    logic             rec_ready = 1'b0;
    logic [REC_W-1:0] rec_data;

    freq_sweep_ctrl u_freq_sweep_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_start_hp(cfg_start_hp),
        .cfg_end_hp(cfg_end_hp), .cfg_settle(cfg_settle), .go(go),
        .busy(busy), .drv_en(drv_en), .drv_half_period(drv_half_period),
        .drv_cycle(drv_cycle), .adc_req(adc_req), .adc_valid(adc_valid),
        .adc_data(adc_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_data(rec_data), .rec_last(rec_last)
    );

    initial forever #4 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [REC_W:0] exp_q[$];
    logic [ADC_W-1:0] exp_seq = '0, adc_seq = '0;
    int exp_settle = 64;
    bit go_req = 0, stall_on = 0, model_busy = 0, restart_pend = 0;
    bit idle_pend = 0, marker_seen = 0, run_loop = 0;
    int pulses = 0, phase = 0, adc_delay = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic run_sweep(input int first, input int last, input int settle);
        cfg_start_hp = HP_W'(first);
        cfg_end_hp   = HP_W'(last);
        cfg_settle   = SW'(settle);
        exp_settle   = (settle == 0) ? 64 : settle;
        for (int hp = first; ; hp++) begin
            exp_q.push_back({1'b0, 16'hFFFF});
            exp_q.push_back({1'b0, REC_W'(hp)});
            for (int k = 0; k < NS; k++) begin
                exp_q.push_back({(k == NS - 1), REC_W'(exp_seq)});
                exp_seq++;
            end
            if (hp >= last) break;
        end
        go_req = 1;
        while (go_req) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (model_busy || busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        // R2: whole record set consumed, nothing extra
        check(exp_q.size() == 0 && !rec_valid, "R2 stream complete", exp_q.size(), 0);
    endtask

    // driver, converter, generator and scoreboard monitor in one negedge process
    initial begin
        wait (run_loop);
        forever begin
            bit rdy;
            @(negedge clk);
            // pulses seen at the posedge just passed
            if (restart_pend) begin
                pulses = 0; restart_pend = 0; marker_seen = 0;
            end else if (drv_cycle) pulses++;
            if (go && !model_busy) begin
                model_busy = 1; pulses = 0; marker_seen = 0;
            end
            if (idle_pend) begin model_busy = 0; idle_pend = 0; end
            // R8 busy tracks the scan
            check(busy == model_busy, "R8 busy", busy, model_busy);
            // R4 drive enable follows busy
            check(drv_en == model_busy, "R4 drv_en", drv_en, model_busy);
            // R5 settle count at first marker offer; R4 half period
            if (rec_valid && !marker_seen && exp_q.size() > 1) begin
                marker_seen = 1;
                check(pulses == exp_settle, "R5 settle cycles", pulses, exp_settle);
                check(drv_half_period == exp_q[1][HP_W-1:0], "R4 half period",
                      drv_half_period, exp_q[1][HP_W-1:0]);
            end
            // R6 no request with a conversion outstanding
            if (adc_req) begin
                check(adc_delay == 0 && !adc_valid, "R6 single request", adc_delay, 0);
            end
            // sink
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = stall_on ? (lfsr[0] | lfsr[3]) : 1'b1;
            rec_ready = rdy;
            if (rec_valid && rdy) begin
                logic [REC_W:0] e;
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected word", {rec_last, rec_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    // R3 record format and order, R6 no sample lost
                    check({rec_last, rec_data} == e, "R3 R6 record word", {rec_last, rec_data}, e);
                    if (e[REC_W]) begin
                        restart_pend = 1;
                        if (exp_q.size() == 0) idle_pend = 1;
                    end
                end
            end
            // converter model: fixed latency, answers only requests
            adc_valid = 1'b0;
            if (adc_req) adc_delay = 3;
            else if (adc_delay > 0) begin
                adc_delay--;
                if (adc_delay == 0) begin
                    adc_valid = 1'b1; adc_data = adc_seq; adc_seq++;
                end
            end
            // tone generator model
            if (!drv_en) begin phase = 0; drv_cycle = 1'b0; end
            else begin
                phase++;
                if (phase >= 2 * int'(drv_half_period)) begin drv_cycle = 1'b1; phase = 0; end
                else drv_cycle = 1'b0;
            end
            go = go_req; go_req = 0;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!busy && !drv_en && !adc_req && !rec_valid && !rec_last, "R1 reset outputs",
              {busy, drv_en, adc_req, rec_valid, rec_last}, 0);
        rst_n = 1'b1;
        run_loop = 1;
        repeat (3) @(negedge clk);
        // R1 idle stays quiet
        check(!rec_valid && !adc_req, "R1 idle quiet", {rec_valid, adc_req}, 0);

        // R2 R3 R6 R7 four-step scan under back-pressure
        stall_on = 1;
        run_sweep(194, 197, 2);
        wait_idle();

        // R5 default settle, R8 go and config change ignored while busy
        stall_on = 0;
        run_sweep(5, 5, 0);
        repeat (30) @(negedge clk);
        cfg_start_hp = 10'd1; cfg_end_hp = 10'd9; cfg_settle = 16'd1;
        go_req = 1;
        while (go_req) @(negedge clk);
        repeat (2) @(negedge clk);
        check(busy, "R8 busy kept through ignored go", busy, 1);
        wait_idle();

        // R2 first value above last value gives one record
        stall_on = 1;
        run_sweep(9, 7, 3);
        wait_idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule